// File: doc/BRIEF.md
# GPIO Register Bank with Mirrored Direction

This block holds the software-visible state of a 32-pin general-purpose I/O port on a 32-bit memory-mapped bus. Software sets pin output levels and pin directions through a plain view plus bit-set and bit-clear views of each register. Each pin also has its own 32-bit configuration word. Bit 0 of that word is the pin's direction, and it always agrees with the matching bit of the packed direction register, whichever path wrote it last.

Pin level resolution, drive strength and pull handling are done by logic outside this block. The block only exports the output and direction vectors and samples the external pin levels into a read-only input register. Accesses to offsets that the map does not define are flagged with a one-cycle error pulse and leave all state unchanged.

Top module: `gpio_bank`

## Requirements
- R1: After a synchronous active-high reset, the output and direction registers and the input register read zero, and every pin's configuration word reads 0x00000002.
- R2: The output register is reached at offsets 0x504 (replace), 0x508 (OR the ones written into the value) and 0x50C (clear the bits written as one). A read from any of the three offsets returns the current output value, and the `out_level` port always shows that value.
- R3: The direction register is reached at offsets 0x514 (replace), 0x518 (set) and 0x51C (clear), with the same meaning as in R2. All three offsets read back the current direction value, and `out_dir` always shows that value.
- R4: After any write through a direction view, bit 0 of every pin's configuration word reads back equal to that pin's direction bit.
- R5: Pin N's configuration word is at offset 0x700 + 4*N. A write to it stores bits 31:1 as written and copies written bit 0 into direction bit N. Other direction bits and other pins' words do not change.
- R6: Offset 0x510 reads the input register, which samples `pin_in` on every clock. A write to 0x510 is treated as an undefined access.
- R7: An access to an undefined offset raises the error flag and returns zero on a read. Undefined offsets include unaligned addresses, unmapped words and writes to the input register. Such an access leaves the output, direction and configuration state unchanged.
- R8: `bus_rdata` and `bus_err` are registered and are valid in the cycle after the access. `bus_err` is low after idle cycles and after defined accesses, and `bus_rdata` is zero after writes and idle cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the access |
| bus_err | output | 1 | Undefined-access pulse, one cycle after the access |
| pin_in | input | 32 | External pin levels |
| out_level | output | 32 | Current output register |
| out_dir | output | 32 | Current direction register |

## Verification
If the split direction storage falls out of step, a configuration read shows the wrong bit 0 on the first read after the direction write. The `out_dir` port shows the wrong bit in the cycle right after a configuration write. A wrong alias decode shows on `out_level` or `out_dir` one cycle after the write. An undefined access that wrongly changes state also shows on those ports one cycle later. A missed error decode shows on `bus_err` one cycle after the access.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int NUM_PINS = 32;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 12;
    localparam int PIN_W    = $clog2(NUM_PINS);

    localparam logic [ADDR_W-1:0] OFS_OUT    = 12'h504;
    localparam logic [ADDR_W-1:0] OFS_OUTSET = 12'h508;
    localparam logic [ADDR_W-1:0] OFS_OUTCLR = 12'h50C;
    localparam logic [ADDR_W-1:0] OFS_IN     = 12'h510;
    localparam logic [ADDR_W-1:0] OFS_DIR    = 12'h514;
    localparam logic [ADDR_W-1:0] OFS_DIRSET = 12'h518;
    localparam logic [ADDR_W-1:0] OFS_DIRCLR = 12'h51C;
    localparam logic [ADDR_W-1:0] OFS_CNF    = 12'h700;

    localparam logic [DATA_W-1:0] CNF_RST = 32'h0000_0002;

    typedef enum logic [1:0] {
        VIEW_PUT = 2'd0,
        VIEW_SET = 2'd1,
        VIEW_CLR = 2'd2
    } view_e;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_OUT,
        SEL_IN,
        SEL_DIR,
        SEL_CNF
    } target_e;

    typedef struct packed {
        target_e          target;
        view_e            view;
        logic [PIN_W-1:0] pin;
    } decode_t;

    function automatic logic [DATA_W-1:0] apply_view(
        input view_e             v,
        input logic [DATA_W-1:0] cur,
        input logic [DATA_W-1:0] wd
    );
        logic [DATA_W-1:0] r;
        case (v)
            VIEW_SET: r = cur | wd;
            VIEW_CLR: r = cur & ~wd;
            default:  r = wd;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
    import gpio_pkg::*;
#(
    parameter int AW    = ADDR_W,
    parameter int PINS  = NUM_PINS,
    parameter int PW    = PIN_W
) (
    input  logic [AW-1:0] addr,
    output decode_t       dec
);
    localparam logic [AW-3:0] CNF_CNT = (AW-2)'(PINS);

    logic [AW-1:0] cnf_off;

    always_comb begin
        cnf_off    = addr - OFS_CNF;
        dec.target = SEL_NONE;
        dec.view   = VIEW_PUT;
        dec.pin    = cnf_off[PW+1:2];
        case (addr)
            OFS_OUT:    begin dec.target = SEL_OUT; dec.view = VIEW_PUT; end
            OFS_OUTSET: begin dec.target = SEL_OUT; dec.view = VIEW_SET; end
            OFS_OUTCLR: begin dec.target = SEL_OUT; dec.view = VIEW_CLR; end
            OFS_IN:     dec.target = SEL_IN;
            OFS_DIR:    begin dec.target = SEL_DIR; dec.view = VIEW_PUT; end
            OFS_DIRSET: begin dec.target = SEL_DIR; dec.view = VIEW_SET; end
            OFS_DIRCLR: begin dec.target = SEL_DIR; dec.view = VIEW_CLR; end
            default: begin
                if (cnf_off[1:0] == 2'b00 && cnf_off[AW-1:2] < CNF_CNT)
                    dec.target = SEL_CNF;
            end
        endcase
    end
endmodule

// File: rtl/gpio_alias_reg.sv
module gpio_alias_reg
    import gpio_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int IW = PIN_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          word_we,
    input  view_e         view,
    input  logic [W-1:0]  wdata,
    input  logic          bit_we,
    input  logic [IW-1:0] bit_idx,
    input  logic          bit_val,
    output logic [W-1:0]  q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (word_we) begin
            q <= apply_view(view, q, wdata);
        end else if (bit_we) begin
            q[bit_idx] <= bit_val;
        end
    end

    a_r2_word_bit_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(word_we && bit_we));
endmodule

// File: rtl/gpio_cnf_bank.sv
module gpio_cnf_bank
    import gpio_pkg::*;
#(
    parameter int PINS = NUM_PINS,
    parameter int W    = DATA_W,
    parameter int PW   = PIN_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    we,
    input  logic [PW-1:0]           idx,
    input  logic [W-2:0]            wdata_hi,
    output logic [PINS-1:0][W-2:0]  hi_q
);
    localparam logic [W-2:0] HI_RST = CNF_RST[W-1:1];

    for (genvar p = 0; p < PINS; p++) begin : g_pin
        always_ff @(posedge clk) begin
            if (rst)
                hi_q[p] <= HI_RST;
            else if (we && idx == PW'(p))
                hi_q[p] <= wdata_hi;
        end
    end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_err,
    input  logic [DATA_W-1:0] pin_in,
    output logic [DATA_W-1:0] out_level,
    output logic [DATA_W-1:0] out_dir
);
    decode_t                         dec;
    logic                            wr, rd, bad;
    logic [DATA_W-1:0]               in_q;
    logic [NUM_PINS-1:0][DATA_W-2:0] cnf_hi;
    logic [DATA_W-1:0]               rd_mux;

    gpio_addr_decode u_dec (
        .addr (bus_addr),
        .dec  (dec)
    );

    assign wr  = bus_valid &&  bus_write;
    assign rd  = bus_valid && !bus_write;
    assign bad = bus_valid && (dec.target == SEL_NONE ||
                               (bus_write && dec.target == SEL_IN));

    gpio_alias_reg u_out (
        .clk     (clk),
        .rst     (rst),
        .word_we (wr && dec.target == SEL_OUT),
        .view    (dec.view),
        .wdata   (bus_wdata),
        .bit_we  (1'b0),
        .bit_idx ('0),
        .bit_val (1'b0),
        .q       (out_level)
    );

    gpio_alias_reg u_dir (
        .clk     (clk),
        .rst     (rst),
        .word_we (wr && dec.target == SEL_DIR),
        .view    (dec.view),
        .wdata   (bus_wdata),
        .bit_we  (wr && dec.target == SEL_CNF),
        .bit_idx (dec.pin),
        .bit_val (bus_wdata[0]),
        .q       (out_dir)
    );

    gpio_cnf_bank u_cnf (
        .clk      (clk),
        .rst      (rst),
        .we       (wr && dec.target == SEL_CNF),
        .idx      (dec.pin),
        .wdata_hi (bus_wdata[DATA_W-1:1]),
        .hi_q     (cnf_hi)
    );

    always_ff @(posedge clk) begin
        if (rst) in_q <= '0;
        else     in_q <= pin_in;
    end

    always_comb begin
        case (dec.target)
            SEL_OUT: rd_mux = out_level;
            SEL_IN:  rd_mux = in_q;
            SEL_DIR: rd_mux = out_dir;
            SEL_CNF: rd_mux = {cnf_hi[dec.pin], out_dir[dec.pin]};
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
            bus_err   <= 1'b0;
        end else begin
            bus_rdata <= (rd && !bad) ? rd_mux : '0;
            bus_err   <= bad;
        end
    end

    // R2: set and clear views act on the output register
    a_r2_set_ors: assert property (@(posedge clk) disable iff (rst)
        (wr && bus_addr == OFS_OUTSET) |=> out_level == ($past(out_level) | $past(bus_wdata)));
    a_r2_clr_masks: assert property (@(posedge clk) disable iff (rst)
        (wr && bus_addr == OFS_OUTCLR) |=> out_level == ($past(out_level) & ~$past(bus_wdata)));
    // R3: set view on the direction register
    a_r3_set_ors: assert property (@(posedge clk) disable iff (rst)
        (wr && bus_addr == OFS_DIRSET) |=> out_dir == ($past(out_dir) | $past(bus_wdata)));
    // R5: configuration write lands bit 0 in direction
    a_r5_cnf_to_dir: assert property (@(posedge clk) disable iff (rst)
        (wr && dec.target == SEL_CNF) |=> out_dir[$past(dec.pin)] == $past(bus_wdata[0]));
    // R7: undefined access flags and changes nothing
    a_r7_bad_no_change: assert property (@(posedge clk) disable iff (rst)
        bad |=> bus_err && bus_rdata == '0 && $stable(out_level) && $stable(out_dir));
    // R8: no error after idle
    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !bus_valid |=> !bus_err && bus_rdata == '0);
endmodule

// File: tb/gpio_bank_bench.sv
module gpio_bank_bench;
    import gpio_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_valid = 1'b0;
    logic              bus_write = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic              bus_err;
    logic [DATA_W-1:0] pin_in = '0;
    logic [DATA_W-1:0] out_level;
    logic [DATA_W-1:0] out_dir;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    gpio_bank u_gpio_bank (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_err(bus_err), .pin_in(pin_in), .out_level(out_level), .out_dir(out_dir)
    );

    typedef struct packed {
        logic        wr;
        logic [11:0] addr;
        logic [31:0] wd;
        logic [31:0] rd;
        logic        err;
    } vec_t;

    localparam int NV = 26;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 12'h504, 32'h0000_00F0, 32'h0, 1'b0},  // R2 put
        '{1'b0, 12'h508, 32'h0, 32'h0000_00F0, 1'b0},  // R2 read via set view
        '{1'b1, 12'h508, 32'h0000_0F00, 32'h0, 1'b0},  // R2 set
        '{1'b0, 12'h504, 32'h0, 32'h0000_0FF0, 1'b0},  // R2
        '{1'b1, 12'h50C, 32'h0000_0030, 32'h0, 1'b0},  // R2 clear
        '{1'b0, 12'h50C, 32'h0, 32'h0000_0FC0, 1'b0},  // R2 read via clear view
        '{1'b1, 12'h514, 32'h0000_0005, 32'h0, 1'b0},  // R3 put
        '{1'b0, 12'h700, 32'h0, 32'h0000_0003, 1'b0},  // R4 pin 0
        '{1'b0, 12'h704, 32'h0, 32'h0000_0002, 1'b0},  // R4 pin 1
        '{1'b0, 12'h708, 32'h0, 32'h0000_0003, 1'b0},  // R4 pin 2
        '{1'b1, 12'h77C, 32'h0000_0301, 32'h0, 1'b0},  // R5 pin 31
        '{1'b0, 12'h518, 32'h0, 32'h8000_0005, 1'b0},  // R5 dir bit 31
        '{1'b0, 12'h77C, 32'h0, 32'h0000_0301, 1'b0},  // R5 readback
        '{1'b1, 12'h51C, 32'h0000_0001, 32'h0, 1'b0},  // R3 clear
        '{1'b0, 12'h514, 32'h0, 32'h8000_0004, 1'b0},  // R3
        '{1'b0, 12'h700, 32'h0, 32'h0000_0002, 1'b0},  // R4 after clear
        '{1'b1, 12'h714, 32'h0000_000C, 32'h0, 1'b0},  // R5 pin 5
        '{1'b0, 12'h714, 32'h0, 32'h0000_000C, 1'b0},  // R5
        '{1'b1, 12'h518, 32'h0000_0020, 32'h0, 1'b0},  // R3 set
        '{1'b0, 12'h714, 32'h0, 32'h0000_000D, 1'b0},  // R4 after set
        '{1'b0, 12'h600, 32'h0, 32'h0, 1'b1},          // R7 read unmapped
        '{1'b1, 12'h600, 32'hFFFF_FFFF, 32'h0, 1'b1},  // R7 write unmapped
        '{1'b1, 12'h506, 32'hFFFF_FFFF, 32'h0, 1'b1},  // R7 unaligned
        '{1'b0, 12'h504, 32'h0, 32'h0000_0FC0, 1'b0},  // R7 output untouched
        '{1'b1, 12'h510, 32'h0000_1234, 32'h0, 1'b1},  // R6 write to input
        '{1'b0, 12'h514, 32'h0, 32'h8000_0024, 1'b0}   // R7 direction untouched
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic access(input logic w, input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1;
        bus_write = w;
        bus_addr  = a;
        bus_wdata = d;
        @(posedge clk);
        #1;
        bus_valid = 1'b0;
        bus_write = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        check("R1 out_level", out_level, 32'h0);
        check("R1 out_dir", out_dir, 32'h0);
        check("R8 err idle", {31'h0, bus_err}, 32'h0);
        access(1'b0, 12'h71C, 32'h0);
        check("R1 cnf7", bus_rdata, 32'h0000_0002);
        access(1'b0, 12'h510, 32'h0);
        check("R1 in", bus_rdata, 32'h0);

        for (int i = 0; i < NV; i++) begin
            access(VEC[i].wr, VEC[i].addr, VEC[i].wd);
            check($sformatf("R8 rdata vec %0d", i), bus_rdata, VEC[i].rd);
            check($sformatf("R7 err vec %0d", i), {31'h0, bus_err}, {31'h0, VEC[i].err});
        end

        // R2 / R3 port mirrors
        check("R2 out_level port", out_level, 32'h0000_0FC0);
        check("R3 out_dir port", out_dir, 32'h8000_0024);

        // R6 input sampling
        @(negedge clk);
        pin_in = 32'hA5A5_0001;
        repeat (2) @(negedge clk);
        access(1'b0, 12'h510, 32'h0);
        check("R6 in read", bus_rdata, 32'hA5A5_0001);

        // R8 idle cycle after access
        @(posedge clk);
        #1;
        check("R8 idle rdata", bus_rdata, 32'h0);
        check("R8 idle err", {31'h0, bus_err}, 32'h0);

        // R4 replace view clears all mirrors
        access(1'b1, 12'h514, 32'h0);
        access(1'b0, 12'h77C, 32'h0);
        check("R4 cnf31 after put", bus_rdata, 32'h0000_0300);

        // R5 last-pin write does not disturb neighbour
        access(1'b0, 12'h778, 32'h0);
        check("R5 cnf30 untouched", bus_rdata, 32'h0000_0002);

        // R7 just past the last configuration word
        access(1'b1, 12'h780, 32'hFFFF_FFFF);
        check("R7 past end err", {31'h0, bus_err}, 32'h1);
        check("R7 past end dir", out_dir, 32'h0);

        // R1 reset mid-run
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1 out after reset", out_level, 32'h0);
        access(1'b0, 12'h77C, 32'h0);
        check("R1 cnf31 after reset", bus_rdata, 32'h0000_0002);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule